// File: doc/BRIEF.md
# Byte-Serial Chained Substitution Core

This block is the confusion engine of a byte-oriented stream generator. It keeps a file of 37 state bytes and an 8-bit accumulator. Once started, it performs one chained substitution step on every clock. Each step reads the byte selected by a rotating pointer, mixes it with the accumulator and an externally supplied key byte, and passes the result through an 8-bit substitution box. The result is kept as the new accumulator and is also written back into the same state byte. The state is never shifted; exactly one byte changes per step.

Before a run, a single load cycle fills the whole state file in parallel, along with the accumulator seed and the starting pointer. Operation then waits for a start command and continues on every following clock until the next load. The whole state file is exposed, so a keystream reader outside the block can pick whichever bytes it needs. Key evolution and output sequencing belong to neighbouring blocks.

Top module: `sbyte_chain_core`

## Requirements
- R1: While reset is asserted, and after it is released, every state byte, the accumulator, the pointer and the run flag read zero.
- R2: A cycle with `load_i` high copies `iv_i` into the state (byte i taken from bits 8i+7..8i) and `acc_init_i` into the accumulator. It sets the pointer to `ptr_init_i`, clears the run flag, and takes priority over `start_i` in the same cycle.
- R3: While the core is idle and not loading, changes on `iv_i`, `key_i`, `acc_init_i` and `ptr_init_i` leave the state, accumulator and pointer unchanged.
- R4: Each step sets the accumulator to S(state[ptr] XOR acc XOR key) and writes the same value into state[ptr].
- R5: A step modifies only the addressed state byte; the other 36 bytes keep their values.
- R6: After each step the pointer advances by one, wrapping from 36 to 0. A load value of 37 or more is replaced by 0.
- R7: The step is already performed on the clock edge that samples `start_i`. Steps then follow on every later clock with no idle cycle, and `run_o` reads one.
- R8: S is the forward AES byte substitution: S(0x00)=0x63, S(0x01)=0x7C, S(0x53)=0xED, S(0xFF)=0x16.
- R9: Asserting `start_i` again while running neither pauses nor repeats anything; steps continue exactly as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Parallel load of state, accumulator seed and pointer |
| iv_i | input | 296 | Initial state bytes, byte i at bits 8i+7..8i |
| acc_init_i | input | 8 | Accumulator seed taken on load |
| ptr_init_i | input | 6 | Starting pointer taken on load |
| start_i | input | 1 | Begin stepping |
| key_i | input | 8 | Key byte mixed into the current step |
| state_o | output | 296 | Whole state file, byte i at bits 8i+7..8i |
| acc_o | output | 8 | Accumulator |
| ptr_o | output | 6 | Current state pointer |
| run_o | output | 1 | Core is stepping |

## Verification
The hardest situations to reach are the pointer wrap from 36 back to 0 in the middle of a run, and the wrap from an unusual start position. Both follow a long uninterrupted run in which every earlier step has already changed the accumulator. The stimulus loads the pointer close to the top of its range and then runs more than two full laps with a key byte that changes every cycle. The whole state file is compared after every edge, so a wrong byte, a write to the wrong byte or a missed step shows up immediately. The S-box is checked separately against known table values by loading a chosen byte at the pointer with a zero seed and a zero key.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t p;
    byte_t x;
    p = '0;
    x = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  // Inverse as a^254 (zero maps to zero)
  function automatic byte_t gf_inv(input byte_t a);
    byte_t sq;
    byte_t r;
    sq = a;
    r  = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  // Forward substitution: inverse followed by the affine map
  function automatic byte_t fwd_sub(input byte_t a);
    byte_t b;
    b = gf_inv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/chain_sbox.sv
module chain_sbox
  import chain_pkg::*;
(
  input  byte_t x_i,
  output byte_t y_o
);
  always_comb y_o = fwd_sub(x_i);
endmodule

// File: rtl/chain_ptr.sv
module chain_ptr #(
  parameter int NUM_BYTES = 37,
  parameter int PTR_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PTR_W-1:0] init_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(NUM_BYTES - 1);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(NUM_BYTES);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = load_i | step_i;
    if (load_i)
      ptr_d = (init_i < LIMIT) ? init_i : '0;
    else if (ptr_q == LAST)
      ptr_d = '0;
    else
      ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q < LIMIT);
  p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ptr_q == LAST) |=> ptr_q == '0);
  p_ptr_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(ptr_q));
endmodule

// File: rtl/chain_state_file.sv
module chain_state_file
  import chain_pkg::*;
#(
  parameter int NUM_BYTES = 37,
  parameter int PTR_W     = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  byte_t [NUM_BYTES-1:0]       iv_i,
  input  logic                        step_i,
  input  logic [PTR_W-1:0]            ptr_i,
  input  byte_t                       wdata_i,
  output byte_t [NUM_BYTES-1:0]       state_o
);
  logic [NUM_BYTES-1:0] wr_en;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    byte_t q, d;
    logic  en;

    always_comb begin
      wr_en[g] = step_i && !load_i && (ptr_i == PTR_W'(g));
      en       = load_i | wr_en[g];
      d        = load_i ? iv_i[g] : wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign state_o[g] = q;
  end

  p_onehot_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  p_wr_when_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |-> $countones(wr_en) == 1);
endmodule

// File: rtl/sbyte_chain_core.sv
module sbyte_chain_core
  import chain_pkg::*;
#(
  parameter  int NUM_BYTES = 37,
  localparam int PTR_W     = $clog2(NUM_BYTES),
  localparam int FLAT_W    = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [FLAT_W-1:0] iv_i,
  input  logic [7:0]        acc_init_i,
  input  logic [PTR_W-1:0]  ptr_init_i,
  input  logic              start_i,
  input  logic [7:0]        key_i,
  output logic [FLAT_W-1:0] state_o,
  output logic [7:0]        acc_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              run_o
);
  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  byte_t [NUM_BYTES-1:0] iv_b, st_b;
  byte_t                 acc_q, acc_d, mix, sub;
  logic                  run_q, run_d, step, acc_en;
  logic [PTR_W-1:0]      ptr;

  assign iv_b = iv_i;

  always_comb begin
    step   = (run_q | start_i) & ~load_i;
    run_d  = load_i ? 1'b0 : 1'b1;
    mix    = st_b[ptr] ^ acc_q ^ key_i;
    acc_en = load_i | step;
    acc_d  = load_i ? acc_init_i : sub;
  end

  chain_sbox u_sbox (.x_i(mix), .y_o(sub));

  chain_ptr #(.NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .load_i(load_i), .init_i(ptr_init_i),
    .step_i(step), .ptr_o(ptr)
  );

  chain_state_file #(.NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) u_state (
    .clk(clk), .rst_n(rst_sync_n), .load_i(load_i), .iv_i(iv_b),
    .step_i(step), .ptr_i(ptr), .wdata_i(sub), .state_o(st_b)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (acc_en)             acc_q <= acc_d;
      if (load_i || start_i)  run_q <= run_d;
    end
  end

  assign state_o = st_b;
  assign acc_o   = acc_q;
  assign ptr_o   = ptr;
  assign run_o   = run_q;

  p_writeback_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step |=> st_b[$past(ptr)] == acc_q);
  p_load_acc_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_i |=> (acc_q == $past(acc_init_i)) && !run_q);
  p_acc_idle_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_i && !run_q && !start_i) |=> $stable(acc_q) && $stable(st_b));
  p_run_after_start_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !load_i) |=> run_q);
endmodule

// File: tb/sbyte_chain_core_test.sv
module sbyte_chain_core_test;
  localparam int NB = 37;
  localparam int FW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_i, start_i;
  logic [FW-1:0] iv_i;
  logic [7:0]    acc_init_i, key_i;
  logic [5:0]    ptr_init_i;
  logic [FW-1:0] state_o;
  logic [7:0]    acc_o;
  logic [5:0]    ptr_o;
  logic          run_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int cyc_cnt = 0;

  logic [7:0] m_st [NB];
  logic [7:0] m_acc;
  int         m_ptr;
  logic       m_run;

  always #5 clk = ~clk;

  sbyte_chain_core uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .iv_i(iv_i),
    .acc_init_i(acc_init_i), .ptr_init_i(ptr_init_i), .start_i(start_i),
    .key_i(key_i), .state_o(state_o), .acc_o(acc_o), .ptr_o(ptr_o), .run_o(run_o)
  );

  // Independent reference: shift-and-add product, inverse by search
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] x);
    logic [7:0] inv = 8'h00;
    logic [7:0] c = 8'h63;
    logic [7:0] y;
    for (int v = 1; v < 256; v++) if (ref_mul(x, 8'(v)) == 8'h01) inv = 8'(v);
    for (int i = 0; i < 8; i++)
      y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return y;
  endfunction

  task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [FW-1:0] e;
    for (int i = 0; i < NB; i++) e[8*i +: 8] = m_st[i];
    chk({tag, " state"}, state_o, e);
    chk({tag, " acc"}, FW'(acc_o), FW'(m_acc));
    chk({tag, " ptr"}, FW'(ptr_o), FW'(m_ptr));
    chk({tag, " run"}, FW'(run_o), FW'(m_run));
  endtask

  // One clock: drive, let the edge pass, update the model, settle
  task automatic cyc(input logic ld, input logic st, input logic [7:0] k);
    logic [7:0] t;
    load_i = ld; start_i = st; key_i = k;
    @(posedge clk);
    if (ld) begin
      for (int i = 0; i < NB; i++) m_st[i] = iv_i[8*i +: 8];
      m_acc = acc_init_i;
      m_ptr = (ptr_init_i < NB) ? int'(ptr_init_i) : 0;
      m_run = 1'b0;
    end else if (m_run || st) begin
      t = ref_sbox(m_st[m_ptr] ^ m_acc ^ k);
      m_acc = t;
      m_st[m_ptr] = t;
      m_ptr = (m_ptr == NB - 1) ? 0 : m_ptr + 1;
      m_run = 1'b1;
    end
    #2;
  endtask

  task automatic fill_iv(input int mul, input int add);
    for (int i = 0; i < NB; i++) iv_i[8*i +: 8] = 8'((i * mul + add) & 8'hFF);
  endtask

  task automatic t_reset;
    rst_n = 1'b1; load_i = 0; start_i = 0; key_i = 0;
    iv_i = '1; acc_init_i = 8'hFF; ptr_init_i = 6'd3;
    for (int i = 0; i < NB; i++) m_st[i] = 8'h00;
    m_acc = 0; m_ptr = 0; m_run = 0;
    #1 rst_n = 1'b0;
    #3 check_all("R1 in reset");
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (3) cyc(1'b0, 1'b0, 8'h00);
    check_all("R1 after release");
  endtask

  task automatic t_load;
    fill_iv(29, 7); acc_init_i = 8'h5A; ptr_init_i = 6'd12;
    cyc(1'b1, 1'b0, 8'h00);
    check_all("R2 load");
    chk("R2 ptr value", FW'(ptr_o), FW'(12));
  endtask

  task automatic t_idle;
    for (int i = 0; i < 5; i++) begin
      fill_iv(3 + i, 100 + i); acc_init_i = 8'(i * 17); ptr_init_i = 6'(i);
      cyc(1'b0, 1'b0, 8'(8'hC3 + i));
    end
    check_all("R3 idle ignores inputs");
  endtask

  task automatic t_sbox;
    logic [7:0] xs [4] = '{8'h00, 8'h01, 8'h53, 8'hFF};
    logic [7:0] ys [4] = '{8'h63, 8'h7C, 8'hED, 8'h16};
    for (int j = 0; j < 4; j++) begin
      iv_i = '0; iv_i[8*5 +: 8] = xs[j]; acc_init_i = 8'h00; ptr_init_i = 6'd5;
      cyc(1'b1, 1'b0, 8'h00);
      cyc(1'b0, 1'b1, 8'h00);
      chk("R8 sbox value", FW'(acc_o), FW'(ys[j]));
      chk("R4 written back", FW'(state_o[8*5 +: 8]), FW'(ys[j]));
    end
  endtask

  task automatic t_start_priority;
    fill_iv(11, 2); acc_init_i = 8'h21; ptr_init_i = 6'd0;
    cyc(1'b1, 1'b1, 8'h44);
    check_all("R2 load beats start");
    chk("R2 run cleared", FW'(run_o), FW'(0));
  endtask

  task automatic t_ptr_oob;
    ptr_init_i = 6'd40;
    cyc(1'b1, 1'b0, 8'h00);
    chk("R6 out of range load", FW'(ptr_o), FW'(0));
    ptr_init_i = 6'd36;
    cyc(1'b1, 1'b0, 8'h00);
    chk("R6 top load", FW'(ptr_o), FW'(36));
    cyc(1'b0, 1'b1, 8'h9E);
    chk("R6 wrap to zero", FW'(ptr_o), FW'(0));
    check_all("R4 R5 wrap step");
  endtask

  task automatic t_long_run;
    fill_iv(29, 7); acc_init_i = 8'h5A; ptr_init_i = 6'd30;
    cyc(1'b1, 1'b0, 8'h00);
    cyc(1'b0, 1'b1, 8'hA5);
    check_all("R7 step on start edge");
    for (int c = 0; c < 90; c++) begin
      fill_iv(c, c);
      cyc(1'b0, (c % 7) == 3, 8'((c * 13) ^ 8'hA5));
      check_all((c % 7) == 3 ? "R9 restart while running" : "R5 R6 R7 run");
    end
  endtask

  initial begin
    t_reset();
    t_load();
    t_idle();
    t_sbox();
    t_start_priority();
    t_ptr_oob();
    t_long_run();
    t_load();
    t_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule